// File: doc/BRIEF.md
# DRAM Read/Write Bus Turnaround Arbiter

This block chooses, cycle by cycle, whether the shared data bus of a DRAM controller carries reads or writes. It looks at the current write-queue fill level, a flag saying a read is ready to issue, a request to flush all pending writes, and a pulse for each write burst the controller actually issues. It drives the bus direction, a per-cycle permission to issue the next write, and a busy flag that holds reads back while the bus turns around from writing to reading.

Writes are not left to pile up until the queue is nearly full. Whenever no read is ready and the queue holds more than a low watermark, the bus switches to writes and uses the idle read time to drain them. Entries up to the low watermark stay queued and act as on-chip write storage. At or above a high watermark, writes take the bus even when reads wait. Once the bus is in write mode, reads can reclaim it only after a minimum number of write bursts, so the cost of each turnaround is spread over several bursts.

Both watermarks come from percentage parameters applied to the queue depth. The queue storage, DRAM command timing and bank state live in other blocks.

Top module: `bus_dir_arbiter`

## Requirements
- R1: The low and high watermarks in entries are floor(WQ_DEPTH*LO_PCT/100) and floor(WQ_DEPTH*HI_PCT/100). The defaults are depth 32, 50 % and 85 %, which give 16 and 27, with MIN_WR_BURSTS 16 and TURN_CYC 4. Elaboration stops with an error when LO_PCT is not strictly below HI_PCT.
- R2: After a synchronous active-low reset, mode_write is 0, turn_busy is 0 and wr_grant is 0, whatever mode the block was in.
- R3: In read mode with turn_busy low, if rd_ready is 0, wq_level is non-zero and either wq_level > low watermark or drain_req is 1, then mode_write is 1 after the next clock edge.
- R4: In read mode with turn_busy low, wq_level >= high watermark sets mode_write to 1 after the next edge, even with rd_ready at 1.
- R5: In read mode the block stays in read mode when wq_level is 0, or when rd_ready is 1 and wq_level is below the high watermark, or when wq_level <= low watermark with drain_req at 0.
- R6: In write mode, wq_level of 0 returns the bus to read mode (mode_write 0) at the next edge.
- R7: In write mode with drain_req at 0, wq_level below the low watermark returns the bus to read mode at the next edge. With drain_req at 1 the bus stays in write mode.
- R8: In write mode, rd_ready at 1 returns the bus to read mode at the next edge once at least MIN_WR_BURSTS bursts have been issued in this write period, unless wq_level is at or above the high watermark.
- R9: The per-period burst count rises by one for each wr_issued pulse seen in write mode. It saturates instead of wrapping, ignores pulses in read mode, and is cleared at each return to read mode.
- R10: On each return to read mode, turn_busy is 1 for exactly TURN_CYC cycles. Throughout that time mode_write and wr_grant stay 0 even if the queue is full.
- R11: wr_grant is 1 exactly when mode_write is 1 and none of the return-to-read conditions of R6 to R8 holds in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wq_level | input | OCC_W ($clog2(WQ_DEPTH+1)) | Current write-queue occupancy in entries |
| rd_ready | input | 1 | A read is ready to issue this cycle |
| drain_req | input | 1 | Request to flush all queued writes |
| wr_issued | input | 1 | One-cycle pulse per issued write burst |
| mode_write | output | 1 | Bus direction: 1 write, 0 read |
| wr_grant | output | 1 | A write burst may be issued this cycle |
| turn_busy | output | 1 | Write-to-read turnaround in progress; reads held off |

## Verification
mode_write and turn_busy are registered and change one clock edge after the inputs that cause them. wr_grant is combinational on the current inputs and mode, so it is valid in the same cycle. The bench drives every input on the falling edge. It reads wr_grant a moment after driving and reads mode_write and turn_busy on the following falling edge, one rising edge later. The turnaround check counts falling edges from the edge where the bus leaves write mode. It expects turn_busy high on exactly TURN_CYC of them and write mode again one edge after turn_busy drops.

// File: rtl/bda_pkg.sv
// Shared types and helpers for the bus direction arbiter.
// Assumes percentages are integers in 0..100.
package bda_pkg;

    typedef enum logic {
        BUS_READ  = 1'b0,
        BUS_WRITE = 1'b1
    } bus_mode_e;

    // Convert a percentage of the queue depth into whole entries (truncating).
    function automatic int unsigned pct_entries(int unsigned depth, int unsigned pct);
        return (depth * pct) / 100;
    endfunction

endpackage

// File: rtl/bda_watermark.sv
// Compares the write-queue fill level against the two watermarks.
// Purely combinational. Assumes LO_LVL < HI_LVL <= 2**OCC_W - 1.
module bda_watermark #(
    parameter int unsigned OCC_W  = 6,
    parameter int unsigned LO_LVL = 16,
    parameter int unsigned HI_LVL = 27
) (
    input  logic [OCC_W-1:0] level,
    output logic             q_empty,
    output logic             over_lo,
    output logic             under_lo,
    output logic             at_hi
);

    localparam logic [OCC_W-1:0] LO_V = OCC_W'(LO_LVL);
    localparam logic [OCC_W-1:0] HI_V = OCC_W'(HI_LVL);

    // Level comparisons against the configured watermarks.
    always_comb begin
        q_empty  = (level == '0);
        over_lo  = (level > LO_V);
        under_lo = (level < LO_V);
        at_hi    = (level >= HI_V);
    end

endmodule

// File: rtl/bda_burst_counter.sv
// Counts write bursts issued during the current write period.
// Saturates at MIN_WR and reports when that minimum has been met.
// Assumes MIN_WR >= 1. Clear takes priority over counting.
module bda_burst_counter #(
    parameter int unsigned MIN_WR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic inc,
    input  logic clear,
    output logic met
);

    localparam int unsigned     CNT_W = $clog2(MIN_WR + 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(MIN_WR);

    logic [CNT_W-1:0] cnt_q;

    // Saturating per-period burst count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en && inc && (cnt_q != CAP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Minimum reached once the count sits at its cap.
    always_comb met = (cnt_q == CAP);

endmodule

// File: rtl/bda_turn_timer.sv
// Write-to-read turnaround countdown. A start pulse loads TURN_CYC;
// busy stays high until the count returns to zero. Assumes TURN_CYC >= 1.
module bda_turn_timer #(
    parameter int unsigned TURN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int unsigned     T_W  = $clog2(TURN_CYC + 1);
    localparam logic [T_W-1:0]  LOAD = T_W'(TURN_CYC);

    logic [T_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Busy while any turnaround cycles remain.
    always_comb busy = (cnt_q != '0);

endmodule

// File: rtl/bus_dir_arbiter.sv
// Decides whether the shared DRAM data bus serves reads or writes.
// Writes drain opportunistically above the low watermark when no read is
// ready, are forced at the high watermark, and hold the bus for a minimum
// number of bursts before reads may reclaim it. Every return to reads
// starts a turnaround window. Assumes wq_level never exceeds WQ_DEPTH.
module bus_dir_arbiter #(
    parameter int unsigned WQ_DEPTH      = 32,
    parameter int unsigned LO_PCT        = 50,
    parameter int unsigned HI_PCT        = 85,
    parameter int unsigned MIN_WR_BURSTS = 16,
    parameter int unsigned TURN_CYC      = 4,
    localparam int unsigned OCC_W        = $clog2(WQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] wq_level,
    input  logic             rd_ready,
    input  logic             drain_req,
    input  logic             wr_issued,
    output logic             mode_write,
    output logic             wr_grant,
    output logic             turn_busy
);

    import bda_pkg::*;

    localparam int unsigned LO_LVL = pct_entries(WQ_DEPTH, LO_PCT);
    localparam int unsigned HI_LVL = pct_entries(WQ_DEPTH, HI_PCT);

    // Configuration legality, checked at elaboration.
    if (LO_PCT >= HI_PCT) begin : g_bad_watermarks
        $error("bus_dir_arbiter: LO_PCT must be strictly below HI_PCT");
    end
    if (MIN_WR_BURSTS < 1 || TURN_CYC < 1) begin : g_bad_counts
        $error("bus_dir_arbiter: MIN_WR_BURSTS and TURN_CYC must be at least 1");
    end

    bus_mode_e mode_q;
    logic      q_empty, over_lo, under_lo, at_hi;
    logic      burst_met;
    logic      enter_ok, leave_now, start_turn;

    bda_watermark #(
        .OCC_W (OCC_W),
        .LO_LVL(LO_LVL),
        .HI_LVL(HI_LVL)
    ) u_wm (
        .level   (wq_level),
        .q_empty (q_empty),
        .over_lo (over_lo),
        .under_lo(under_lo),
        .at_hi   (at_hi)
    );

    // Switch decisions for the current cycle.
    always_comb begin
        enter_ok   = !turn_busy && !q_empty &&
                     (at_hi || (!rd_ready && (over_lo || drain_req)));
        leave_now  = q_empty ||
                     (under_lo && !drain_req) ||
                     (rd_ready && burst_met && !at_hi);
        start_turn = (mode_q == BUS_WRITE) && leave_now;
    end

    // Bus direction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= BUS_READ;
        end else begin
            unique case (mode_q)
                BUS_READ:  if (enter_ok)  mode_q <= BUS_WRITE;
                BUS_WRITE: if (leave_now) mode_q <= BUS_READ;
                default:                  mode_q <= BUS_READ;
            endcase
        end
    end

    bda_burst_counter #(
        .MIN_WR(MIN_WR_BURSTS)
    ) u_bursts (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(mode_q == BUS_WRITE),
        .inc     (wr_issued),
        .clear   (start_turn),
        .met     (burst_met)
    );

    bda_turn_timer #(
        .TURN_CYC(TURN_CYC)
    ) u_turn (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_turn),
        .busy (turn_busy)
    );

    // Output drive.
    always_comb begin
        mode_write = (mode_q == BUS_WRITE);
        wr_grant   = (mode_q == BUS_WRITE) && !leave_now;
    end

endmodule

// File: rtl/bus_dir_arbiter_chk.sv
// Temporal checks on the arbiter's ports, bound into every instance.
module bus_dir_arbiter_chk #(
    parameter int unsigned OCC_W  = 6,
    parameter int unsigned HI_LVL = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OCC_W-1:0] wq_level,
    input logic             rd_ready,
    input logic             mode_write,
    input logic             wr_grant,
    input logic             turn_busy
);

    localparam logic [OCC_W-1:0] HI_V = OCC_W'(HI_LVL);

    AST_TURN_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        turn_busy |-> (!mode_write && !wr_grant)); // R10

    AST_EXIT_STARTS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_write) |-> turn_busy); // R10

    AST_GRANT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> (mode_write && wq_level != '0)); // R11

    AST_EMPTY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_write && wq_level == '0) |=> !mode_write); // R6

    AST_HIGH_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_write && !turn_busy && wq_level >= HI_V) |=> mode_write); // R4

    AST_NO_EMPTY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_write && wq_level == '0) |=> !mode_write); // R5

    AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_write && rd_ready && wq_level < HI_V) |=> !mode_write); // R5

endmodule

bind bus_dir_arbiter bus_dir_arbiter_chk #(
    .OCC_W (OCC_W),
    .HI_LVL(HI_LVL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wq_level  (wq_level),
    .rd_ready  (rd_ready),
    .mode_write(mode_write),
    .wr_grant  (wr_grant),
    .turn_busy (turn_busy)
);

// File: tb/test_bus_dir_arbiter.sv
`timescale 1ns/1ps
module test_bus_dir_arbiter;

    localparam int DEPTH = 32;
    localparam int LOPCT = 50;
    localparam int HIPCT = 85;
    localparam int MINW  = 16;
    localparam int TURN  = 4;
    localparam int OW    = $clog2(DEPTH + 1);
    localparam int LO    = (DEPTH * LOPCT) / 100;   // R1: 16
    localparam int HI    = (DEPTH * HIPCT) / 100;   // R1: 27

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [OW-1:0] wq_level = '0;
    logic          rd_ready = 1'b0;
    logic          drain_req = 1'b0;
    logic          wr_issued = 1'b0;
    logic          mode_write, wr_grant, turn_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_dir_arbiter #(
        .WQ_DEPTH(DEPTH), .LO_PCT(LOPCT), .HI_PCT(HIPCT),
        .MIN_WR_BURSTS(MINW), .TURN_CYC(TURN)
    ) i_bus_dir_arbiter (
        .clk(clk), .rst_n(rst_n), .wq_level(wq_level), .rd_ready(rd_ready),
        .drain_req(drain_req), .wr_issued(wr_issued),
        .mode_write(mode_write), .wr_grant(wr_grant), .turn_busy(turn_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wq_level = '0; rd_ready = 1'b0; drain_req = 1'b0; wr_issued = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Enter write mode through the forced path (full queue, read waiting).
    task automatic force_write();
        wq_level = OW'(DEPTH); rd_ready = 1'b1; drain_req = 1'b0;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2: reset state, also after having been in write mode
        do_reset();
        check("R2 mode", int'(mode_write), 0);
        check("R2 busy", int'(turn_busy), 0);
        check("R2 grant", int'(wr_grant), 0);
        force_write();
        check("R4 forced entry", int'(mode_write), 1);
        do_reset();
        check("R2 mode after write", int'(mode_write), 0);
        check("R2 grant after write", int'(wr_grant), 0);

        // Entry sweep: every level, read flag and drain flag from idle read mode
        for (int lv = 0; lv <= DEPTH; lv++) begin
            for (int rd = 0; rd < 2; rd++) begin
                for (int dr = 0; dr < 2; dr++) begin
                    bit exp_in;
                    string tag;
                    do_reset();
                    wq_level = OW'(lv); rd_ready = rd[0]; drain_req = dr[0];
                    @(negedge clk);
                    exp_in = (lv != 0) && ((lv >= HI) || (rd == 0 && (lv > LO || dr == 1)));
                    tag = (lv != 0 && lv >= HI) ? "R4" : (exp_in ? "R3" : "R5");
                    if (lv == LO || lv == LO + 1 || lv == HI - 1 || lv == HI)
                        tag = {tag, " R1 boundary"};
                    check($sformatf("%s entry lvl=%0d rd=%0d dr=%0d", tag, lv, rd, dr),
                          int'(mode_write), int'(exp_in));
                end
            end
        end

        // Exit sweep: every level, read flag, drain flag and burst count
        for (int np = 0; np < 3; np++) begin
            for (int lv = 0; lv <= DEPTH; lv++) begin
                for (int rd = 0; rd < 2; rd++) begin
                    for (int dr = 0; dr < 2; dr++) begin
                        int    pulses, eff;
                        bit    exp_out;
                        string tag;
                        pulses = (np == 0) ? 0 : ((np == 1) ? MINW - 1 : 40);
                        eff = (pulses > MINW) ? MINW : pulses;   // R9 saturation
                        do_reset();
                        force_write();
                        wq_level = OW'(DEPTH);
                        for (int k = 0; k < pulses; k++) begin
                            wr_issued = 1'b1;
                            @(negedge clk);
                        end
                        wr_issued = 1'b0;
                        wq_level = OW'(lv); rd_ready = rd[0]; drain_req = dr[0];
                        exp_out = (lv == 0) || (lv < LO && dr == 0) ||
                                  (rd == 1 && eff >= MINW && lv < HI);
                        if (lv == 0)                 tag = "R6";
                        else if (lv < LO && dr == 0) tag = "R7";
                        else if (exp_out)            tag = "R8";
                        else                         tag = "R9 stay";
                        #1;
                        check($sformatf("R11 grant %s lvl=%0d rd=%0d dr=%0d n=%0d", tag, lv, rd, dr, pulses),
                              int'(wr_grant), int'(!exp_out));
                        @(negedge clk);
                        check($sformatf("%s exit lvl=%0d rd=%0d dr=%0d n=%0d", tag, lv, rd, dr, pulses),
                              int'(mode_write), int'(!exp_out));
                    end
                end
            end
        end

        // R9: pulses in read mode are ignored
        do_reset();
        wr_issued = 1'b1;
        repeat (20) @(negedge clk);
        wr_issued = 1'b0;
        force_write();
        wq_level = OW'(20); rd_ready = 1'b1;
        @(negedge clk);
        check("R9 read-mode pulses ignored", int'(mode_write), 1);

        // R9: count cleared on return to reads
        do_reset();
        force_write();
        wq_level = OW'(DEPTH);
        wr_issued = 1'b1;
        repeat (MINW) @(negedge clk);
        wr_issued = 1'b0;
        wq_level = '0;
        @(negedge clk);
        wq_level = '0;
        repeat (TURN + 1) @(negedge clk);
        force_write();
        wq_level = OW'(20); rd_ready = 1'b1;
        @(negedge clk);
        check("R9 count cleared on switch", int'(mode_write), 1);

        // R10: turnaround window length and write lock-out
        do_reset();
        force_write();
        wq_level = '0;
        @(negedge clk);
        wq_level = OW'(DEPTH); rd_ready = 1'b0;
        for (int t = 0; t < TURN; t++) begin
            check($sformatf("R10 busy t=%0d", t), int'(turn_busy), 1);
            check($sformatf("R10 read mode t=%0d", t), int'(mode_write), 0);
            check($sformatf("R10 no grant t=%0d", t), int'(wr_grant), 0);
            @(negedge clk);
        end
        check("R10 busy released", int'(turn_busy), 0);
        check("R10 still read", int'(mode_write), 0);
        @(negedge clk);
        check("R10 write after window", int'(mode_write), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule